// File: doc/BRIEF.md
# DMA interrupt status and mask

This block collects end-of-transfer events from the channels of a DMA controller and turns them into one interrupt line for the processor. Each channel has a sticky status bit and an enable (mask) bit. A channel raises its status bit with a one-cycle finish pulse. Software clears status bits and flips mask bits through a single 32-bit register.

The register uses write-one semantics in both halves, with different effects. A one in the low half clears the matching status bit. A one in the high half inverts the matching mask bit. A zero leaves the bit unchanged. A read returns both halves together. The interrupt output is the OR of the status bits that are also enabled by the mask.

The channel count is a parameter of up to 15. The register width is a parameter that defaults to 32 bits. The status field starts at bit 0, and the mask field starts at half the register width.

Top module: `dmairq_top`

## Requirements
- R1: A high `finishPulse[n]` at a rising clock edge sets status bit n. The bit reads as 1 in `rdData[n]` from that edge on, and it stays set until software clears it.
- R2: A write (`wrEn` high at a rising edge) with `wrData[n]` = 1, for n from 0 to 14, clears status bit n. Status bits whose data bit is 0 keep their value.
- R3: A write with `wrData[16+n]` = 1 inverts mask bit n. Mask bits whose data bit is 0 keep their value.
- R4: `rdData` carries status bit n in bit n (bits 14:0) and mask bit n in bit 16+n (bits 30:16). The read value reflects the register state after the most recent edge.
- R5: `irqOut` is high exactly when some channel has both its status bit and its mask bit set.
- R6: While `rstN` is low, status and mask are all zero and `irqOut` is low.
- R7: If a finish pulse and a write-one clear for the same status bit arrive at the same edge, the bit ends up set.
- R8: `rdData[15]` and `rdData[31]` always read 0. Ones written to these bit positions change no status bit and no mask bit.
- R9: With `wrEn` low, `wrData` has no effect. Without a finish pulse or a clear, status holds; without a write, mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| finishPulse | input | NUM_CH | One bit per channel; a high bit sets that channel's status bit |
| wrEn | input | 1 | Register write strobe |
| wrData | input | REG_W | Write data: clear bits in 14:0, toggle bits in 30:16 |
| rdData | output | REG_W | Status in 14:0, mask in 30:16, other bits zero |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench targets a finish pulse that arrives together with a clear of the same bit. A design that lets the clear win would lose the event, and the bench would see status 0 where it expects 1.

Writing the same toggle bit twice must restore the mask bit. A design that loads the mask instead of toggling it would leave the bit at the written value, so the second write would not turn it off.

Writes of all ones, and writes to bits 15 and 31, expose any misplaced field boundary or reserved bit that a design lets through. Other stimuli change status or mask without changing the other half. A wrong interrupt equation then shows up as a wrong `irqOut` level.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  // Default number of channels tracked by the block.
  localparam int DEF_CH = 15;

  // Default width of the combined status/mask register.
  localparam int DEF_REG_W = 32;

  // Per-cycle strobes that the control passes to the datapath.
  typedef struct packed {
    logic clrEn;  // software clear of status bits this cycle
    logic tglEn;  // software toggle of mask bits this cycle
  } irqStrb_t;

endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int REG_W  = DEF_REG_W
) (
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output irqStrb_t          strb,
  output logic [NUM_CH-1:0] clrVec,
  output logic [NUM_CH-1:0] tglVec
);

  localparam int HALF = REG_W / 2;

  // Bit positions that are part of the status field or the mask field.
  localparam logic [REG_W-1:0] LOW_FIELD  = {{(REG_W-NUM_CH){1'b0}}, {NUM_CH{1'b1}}};
  localparam logic [REG_W-1:0] FIELD_BITS = LOW_FIELD | (LOW_FIELD << HALF);

  // Reserved data bits take no part in any update.
  logic unusedBits;
  assign unusedBits = ^(wrData & ~FIELD_BITS);

  // Extract the clear field and the toggle field from the write data.
  assign clrVec = wrData[NUM_CH-1:0];
  assign tglVec = wrData[HALF+NUM_CH-1:HALF];

  // A strobe is raised only when the write carries a one in its field.
  always_comb begin
    strb.clrEn = wrEn && (|clrVec);
    strb.tglEn = wrEn && (|tglVec);
  end

endmodule

// File: rtl/dmairq_dp.sv
module dmairq_dp
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = DEF_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] finishPulse,
  input  irqStrb_t          strb,
  input  logic [NUM_CH-1:0] clrVec,
  input  logic [NUM_CH-1:0] tglVec,
  output logic [NUM_CH-1:0] statusQ,
  output logic [NUM_CH-1:0] maskQ,
  output logic              irqOut
);

  logic [NUM_CH-1:0] statusD;
  logic [NUM_CH-1:0] maskD;

  // Status: the clear is applied first and the set after it, so a
  // hardware set wins over a software clear in the same cycle.
  always_comb begin
    statusD = statusQ;
    if (strb.clrEn) statusD = statusD & ~clrVec;
    statusD = statusD | finishPulse;
  end

  // Mask: a write inverts the selected bits.
  always_comb begin
    maskD = maskQ;
    if (strb.tglEn) maskD = maskQ ^ tglVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
    end
  end

  // The interrupt is a function of the registers only.
  assign irqOut = |(statusQ & maskQ);

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int REG_W  = DEF_REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] finishPulse,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut
);

  localparam int HALF = REG_W / 2;

  irqStrb_t          strb;
  logic [NUM_CH-1:0] clrVec;
  logic [NUM_CH-1:0] tglVec;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] maskQ;

  dmairq_ctrl #(.NUM_CH(NUM_CH), .REG_W(REG_W)) uCtrl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .strb   (strb),
    .clrVec (clrVec),
    .tglVec (tglVec)
  );

  dmairq_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .finishPulse (finishPulse),
    .strb        (strb),
    .clrVec      (clrVec),
    .tglVec      (tglVec),
    .statusQ     (statusQ),
    .maskQ       (maskQ),
    .irqOut      (irqOut)
  );

  // Read word: status in the low half, mask in the high half, rest zero.
  always_comb begin
    rdData = '0;
    rdData[NUM_CH-1:0] = statusQ;
    rdData[HALF+NUM_CH-1:HALF] = maskQ;
  end

endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk #(
  parameter int NUM_CH = 15,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] finishPulse,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  rdData,
  input logic              irqOut
);

  localparam int HALF = REG_W / 2;

  logic [NUM_CH-1:0] stat;
  logic [NUM_CH-1:0] msk;
  assign stat = rdData[NUM_CH-1:0];
  assign msk  = rdData[HALF+NUM_CH-1:HALF];

  // R1 R7
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|finishPulse) |=> ((stat & $past(finishPulse)) == $past(finishPulse)));

  // R2
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((stat & $past(wrData[NUM_CH-1:0] & ~finishPulse)) == '0));

  // R3
  mask_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (msk == ($past(msk) ^ $past(wrData[HALF+NUM_CH-1:HALF]))));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(msk));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(|finishPulse)) |=> $stable(stat));

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(stat & msk)));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[HALF-1] == 1'b0) && (rdData[REG_W-1] == 1'b0));

endmodule

bind dmairq_top dmairq_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .finishPulse (finishPulse),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .irqOut      (irqOut)
);

// File: tb/tb_dmairq_top.sv
module tb_dmairq_top;

  localparam int NCH = 15;
  localparam int RW  = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] finishPulse = '0;
  logic           wrEn = 1'b0;
  logic [RW-1:0]  wrData = '0;
  logic [RW-1:0]  rdData;
  logic           irqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dmairq_top #(.NUM_CH(NCH), .REG_W(RW)) dut (
    .clk(clk), .rstN(rstN), .finishPulse(finishPulse),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [14:0] fin;
    logic        we;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        irq;
  } vec_t;

  // Each row: stimulus for one edge, then the expected read word and irq.
  localparam vec_t VECS [14] = '{
    '{15'h0001, 1'b0, 32'h00000000, 32'h00000001, 1'b0},  // R1 set ch0
    '{15'h0000, 1'b1, 32'h00010000, 32'h00010001, 1'b1},  // R3 R5 enable ch0
    '{15'h0000, 1'b1, 32'h00000001, 32'h00010000, 1'b0},  // R2 clear ch0
    '{15'h4002, 1'b0, 32'h00000000, 32'h00014002, 1'b0},  // R1 R4 set ch1, ch14
    '{15'h0000, 1'b1, 32'h40000000, 32'h40014002, 1'b1},  // R3 R4 enable ch14
    '{15'h0000, 1'b1, 32'h00010000, 32'h40004002, 1'b1},  // R3 toggle ch0 back off
    '{15'h0000, 1'b1, 32'h00004000, 32'h40000002, 1'b0},  // R2 R5 clear ch14
    '{15'h0002, 1'b1, 32'h00000002, 32'h40000002, 1'b0},  // R7 set beats clear
    '{15'h0000, 1'b1, 32'h80008000, 32'h40000002, 1'b0},  // R8 reserved bits
    '{15'h0000, 1'b1, 32'h7FFF7FFF, 32'h3FFF0000, 1'b0},  // R2 R3 all ones
    '{15'h0100, 1'b0, 32'h00000000, 32'h3FFF0100, 1'b1},  // R1 R5 set ch8
    '{15'h0000, 1'b1, 32'h00000000, 32'h3FFF0100, 1'b1},  // R9 write of zeros
    '{15'h0000, 1'b0, 32'hFFFFFFFF, 32'h3FFF0100, 1'b1},  // R9 data without strobe
    '{15'h0000, 1'b1, 32'h01000000, 32'h3EFF0100, 1'b0}   // R3 R5 mask ch8 off
  };

  task automatic checkOut(input string tag, input logic [31:0] expRd, input logic expIrq);
    checks++;
    if (rdData !== expRd) begin
      errors++;
      $display("FAIL %s rdData actual %08h expected %08h", tag, rdData, expRd);
    end
    checks++;
    if (irqOut !== expIrq) begin
      errors++;
      $display("FAIL %s irqOut actual %0b expected %0b", tag, irqOut, expIrq);
    end
  endtask

  // Drive for one edge, return the inputs to idle, and leave time for
  // the registers to settle before the caller checks.
  task automatic step(input logic [14:0] fin, input logic we, input logic [31:0] wd);
    @(negedge clk);
    finishPulse = fin;
    wrEn = we;
    wrData = wd;
    @(posedge clk);
    #1;
    finishPulse = '0;
    wrEn = 1'b0;
    wrData = '0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R6 reset state, with inputs active during reset
    finishPulse = '1;
    wrEn = 1'b1;
    wrData = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R6 during reset", 32'h0, 1'b0);
    finishPulse = '0;
    wrEn = 1'b0;
    wrData = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R6 after reset", 32'h0, 1'b0);

    for (int i = 0; i < 14; i++) begin
      step(VECS[i].fin, VECS[i].we, VECS[i].wd);
      checkOut($sformatf("R4 R5 vector %0d", i), VECS[i].rd, VECS[i].irq);
    end

    // R8 all ones written: status cleared, mask 0x3EFF ^ 0x7FFF, bits 15/31 low
    step(15'h0000, 1'b1, 32'hFFFFFFFF);
    checkOut("R8 all ones", 32'h41000000, 1'b0);

    // R7 set and clear on several bits at once
    step(15'h7FFF, 1'b1, 32'h00007FFF);
    checkOut("R7 full set vs clear", 32'h41007FFF, 1'b1);

    // R6 reset in the middle of operation
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R6 async reset", 32'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step(15'h0000, 1'b0, 32'h0);
    checkOut("R6 post reset idle", 32'h0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule